// File: doc/BRIEF.md
# ADC Conversion Sequencer and Register Front End

This block sits between a byte-wide register bus and an analog-to-digital converter core. Software turns the converter on and selects single or continuous operation through a control register. It then requests a conversion through a command register. The block issues a one-cycle start pulse to the converter and waits for the converter's done pulse with its 16-bit result. It captures that result, raises a result-ready flag, and tests the result against a programmable low/high window. A per-flag enable mask combines the two flags into one interrupt line.

A start request that arrives while a conversion is running is held and issued when that conversion ends. The command bit reads back as busy until the work is finished. Flags clear when software writes 1 to them, and also when software reads the low result byte. That read also freezes the high result byte, so a later conversion cannot tear the 16-bit value. Turning the enable bit off stops the sequence at once.

Register addresses: 0 control, 1 command, 2 interrupt enable, 3 flags, 4 window mode, 5 result low, 6 result high (snapshot), 7/8 low threshold low/high byte, 9/10 high threshold low/high byte. Control register bits: 0 enable, 1 continuous mode, 3:2 resolution select, 4 left adjust, 5 conversion mode, 7 standby run. Bit 6 reads 0. Only bits 0 and 1 affect sequencing.

Top module: `adc_seq_regs`

## Requirements
- R1: After reset, the control, command, flag and interrupt-enable registers read 0, conv_start is 0 and irq is 0.
- R2: Writing 1 to command bit 0 while control bit 0 (enable) is 0 issues no conv_start, and command bit 0 keeps reading 0.
- R3: With enable set and no conversion running, writing 1 to command bit 0 drives conv_start high for exactly one cycle. Command bit 0 then reads 1 until the conversion's done pulse is taken.
- R4: A start written while a conversion runs produces exactly one further conv_start after the running conversion's done. Writing 0 to command bit 0 starts nothing.
- R5: A done pulse taken during a conversion loads conv_result into the result register and sets flag bit 0 (result ready).
- R6: At that same done, flag bit 1 (window) is set only if the new result meets window mode bits [2:0]. The modes are 0 never, 1 result < low, 2 result > high, 3 low <= result <= high, 4 result < low or result > high, and 5 to 7 never. The thresholds are unsigned 16-bit values.
- R7: Reading the result low byte (address 5) clears both flags.
- R8: Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. A set at the same edge wins over a clear.
- R9: irq is 1 exactly when (flag0 and interrupt-enable bit 0) or (flag1 and interrupt-enable bit 1) holds.
- R10: Reading the result low byte captures the result's high byte. Address 6 returns that captured byte even after a later conversion replaces the result.
- R11: With control bit 1 (continuous) set, one start request launches a chain in which each taken done launches the next conversion.
- R12: Clearing enable while a conversion runs drops busy at once. Any later done is ignored, and no flag is set.
- R13: The control register bits 0 to 5 and 7 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe; read side effects occur at the clock edge |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| conv_start | output | 1 | One-cycle request to the converter |
| conv_done | input | 1 | One-cycle completion from the converter |
| conv_result | input | 16 | Result word, valid with conv_done |
| irq | output | 1 | Interrupt request |

## Verification
A wrong sequencer state shows up at conv_start within one cycle of a command write or a done pulse. It appears as a missing pulse, an extra pulse or a pulse after disable. It also shows on the command busy bit at the next read. A wrong flag or window decision is visible on the flag register and on irq in the cycle after the done pulse. A wrong clear or snapshot shows on the next read of the flags or of the high result byte.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int RES_W  = 16;
    localparam int NFLAG  = 2;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_CMD   = 4'd1;
    localparam logic [ADDR_W-1:0] A_IEN   = 4'd2;
    localparam logic [ADDR_W-1:0] A_FLAG  = 4'd3;
    localparam logic [ADDR_W-1:0] A_WMODE = 4'd4;
    localparam logic [ADDR_W-1:0] A_RESL  = 4'd5;
    localparam logic [ADDR_W-1:0] A_RESH  = 4'd6;
    localparam logic [ADDR_W-1:0] A_LOL   = 4'd7;
    localparam logic [ADDR_W-1:0] A_LOH   = 4'd8;
    localparam logic [ADDR_W-1:0] A_HIL   = 4'd9;
    localparam logic [ADDR_W-1:0] A_HIH   = 4'd10;

    localparam int FLG_RDY = 0;
    localparam int FLG_WIN = 1;

    typedef enum logic [2:0] {
        WIN_OFF     = 3'd0,
        WIN_BELOW   = 3'd1,
        WIN_ABOVE   = 3'd2,
        WIN_INSIDE  = 3'd3,
        WIN_OUTSIDE = 3'd4
    } win_mode_e;

    typedef struct packed {
        logic       stby_run;
        logic       rsvd6;
        logic       conv_mode;
        logic       left_adj;
        logic [1:0] res_sel;
        logic       cont;
        logic       enable;
    } ctrl_t;
endpackage

// File: rtl/adc_win_cmp.sv
module adc_win_cmp
    import adc_seq_pkg::*;
#(
    parameter int W = RES_W
) (
    input  logic [2:0]   mode,
    input  logic [W-1:0] value,
    input  logic [W-1:0] lo_th,
    input  logic [W-1:0] hi_th,
    output logic         match
);
    logic below, above;

    always_comb begin
        below = value < lo_th;
        above = value > hi_th;
        unique case (mode)
            WIN_BELOW:   match = below;
            WIN_ABOVE:   match = above;
            WIN_INSIDE:  match = !below && !above;
            WIN_OUTSIDE: match = below || above;
            default:     match = 1'b0;
        endcase
    end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cont,
    input  logic start_req,
    input  logic conv_done,
    output logic conv_start,
    output logic busy,
    output logic pend,
    output logic done_ok
);
    typedef struct packed {
        logic start;
        logic busy;
        logic pend;
    } seq_t;

    seq_t s_d, s_q;
    logic launch;

    assign done_ok = conv_done && s_q.busy && en;

    always_comb begin
        s_d    = s_q;
        launch = 1'b0;
        if (!en) begin
            s_d = '0;
        end else begin
            if (done_ok) begin
                if (s_q.pend || cont) begin
                    launch = 1'b1;
                    s_d.pend = start_req;
                end else begin
                    s_d.busy = 1'b0;
                    launch   = start_req;
                end
            end else if (s_q.busy) begin
                if (start_req) s_d.pend = 1'b1;
            end else begin
                launch = start_req;
            end
            s_d.start = launch;
            if (launch) s_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign conv_start = s_q.start;
    assign busy       = s_q.busy;
    assign pend       = s_q.pend;
endmodule

// File: rtl/adc_flag_unit.sv
module adc_flag_unit
    import adc_seq_pkg::*;
#(
    parameter int N = NFLAG
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    input  logic [N-1:0] ien,
    output logic [N-1:0] flags,
    output logic         irq
);
    typedef struct packed {
        logic [N-1:0] flg;
    } flag_t;

    flag_t f_d, f_q;
    logic [N-1:0] req;

    always_comb begin
        f_d.flg = (f_q.flg & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_req
        assign req[i] = f_q.flg[i] & ien[i];
    end

    assign flags = f_q.flg;
    assign irq   = |req;
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              conv_start,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    output logic              irq
);
    localparam int HB = RES_W - DATA_W;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [NFLAG-1:0]  ien;
        logic [2:0]        wmode;
        logic [RES_W-1:0]  lo_th;
        logic [RES_W-1:0]  hi_th;
        logic [RES_W-1:0]  res;
        logic [DATA_W-1:0] hi_snap;
    } regs_t;

    regs_t r_d, r_q;

    logic wr_ctrl, wr_cmd, wr_flag, rd_resl;
    logic start_req, busy, pend, done_ok, win_hit;
    logic [NFLAG-1:0] flags, set_vec, clr_vec;

    assign wr_ctrl   = bus_we && bus_addr == A_CTRL;
    assign wr_cmd    = bus_we && bus_addr == A_CMD;
    assign wr_flag   = bus_we && bus_addr == A_FLAG;
    assign rd_resl   = bus_re && bus_addr == A_RESL;
    assign start_req = wr_cmd && bus_wdata[0];

    always_comb begin
        r_d = r_q;
        if (wr_ctrl) begin
            r_d.ctrl       = ctrl_t'(bus_wdata);
            r_d.ctrl.rsvd6 = 1'b0;
        end
        if (bus_we) begin
            unique case (bus_addr)
                A_IEN:   r_d.ien   = bus_wdata[NFLAG-1:0];
                A_WMODE: r_d.wmode = bus_wdata[2:0];
                A_LOL:   r_d.lo_th[DATA_W-1:0]     = bus_wdata;
                A_LOH:   r_d.lo_th[RES_W-1:DATA_W] = bus_wdata[HB-1:0];
                A_HIL:   r_d.hi_th[DATA_W-1:0]     = bus_wdata;
                A_HIH:   r_d.hi_th[RES_W-1:DATA_W] = bus_wdata[HB-1:0];
                default: ;
            endcase
        end
        if (rd_resl) r_d.hi_snap = DATA_W'(r_q.res[RES_W-1:DATA_W]);
        if (done_ok) r_d.res = conv_result;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    adc_conv_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (r_d.ctrl.enable),
        .cont       (r_q.ctrl.cont),
        .start_req  (start_req),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .busy       (busy),
        .pend       (pend),
        .done_ok    (done_ok)
    );

    adc_win_cmp #(.W(RES_W)) u_win (
        .mode  (r_q.wmode),
        .value (conv_result),
        .lo_th (r_q.lo_th),
        .hi_th (r_q.hi_th),
        .match (win_hit)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[FLG_RDY] = done_ok;
        set_vec[FLG_WIN] = done_ok && win_hit;
        clr_vec          = (wr_flag ? bus_wdata[NFLAG-1:0] : '0) | {NFLAG{rd_resl}};
    end

    adc_flag_unit #(.N(NFLAG)) u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .ien     (r_q.ien),
        .flags   (flags),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:  bus_rdata = r_q.ctrl;
            A_CMD:   bus_rdata[0] = busy || pend;
            A_IEN:   bus_rdata[NFLAG-1:0] = r_q.ien;
            A_FLAG:  bus_rdata[NFLAG-1:0] = flags;
            A_WMODE: bus_rdata[2:0] = r_q.wmode;
            A_RESL:  bus_rdata = r_q.res[DATA_W-1:0];
            A_RESH:  bus_rdata = r_q.hi_snap;
            A_LOL:   bus_rdata = r_q.lo_th[DATA_W-1:0];
            A_LOH:   bus_rdata[HB-1:0] = r_q.lo_th[RES_W-1:DATA_W];
            A_HIL:   bus_rdata = r_q.hi_th[DATA_W-1:0];
            A_HIH:   bus_rdata[HB-1:0] = r_q.hi_th[RES_W-1:DATA_W];
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/adc_seq_regs_chk.sv
module adc_seq_regs_chk
    import adc_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic              bus_re,
    input logic              conv_start,
    input logic              conv_done,
    input logic              busy,
    input logic              pend,
    input logic              en_q,
    input logic [NFLAG-1:0]  flags
);
    AST_RDY_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLG_RDY]) |-> $past(conv_done)); // R5
    AST_WIN_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLG_WIN]) |-> $past(conv_done)); // R6
    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !conv_start); // R2
    AST_BUSY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> en_q); // R12
    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy); // R3
    AST_ZERO_CMD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CMD && !bus_wdata[0] && !busy && !pend) |=> !conv_start); // R4
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == A_RESL && !conv_done) |=> flags == '0); // R7
endmodule

bind adc_seq_regs adc_seq_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_we     (bus_we),
    .bus_re     (bus_re),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .busy       (busy),
    .pend       (pend),
    .en_q       (r_q.ctrl.enable),
    .flags      (flags)
);

// File: tb/adc_seq_regs_bench.sv
`timescale 1ns/1ps
module adc_seq_regs_bench;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [7:0]  bus_rdata;
    logic        conv_start, conv_done = 1'b0, irq;
    logic [15:0] conv_result = '0;

    int n_run = 0, n_fail = 0, n_start = 0;
    logic [15:0] samp_q[$];
    logic [15:0] exp_q[$];

    always #4 clk = ~clk;

    adc_seq_regs u_adc_seq_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .conv_start(conv_start), .conv_done(conv_done),
        .conv_result(conv_result), .irq(irq));

    // converter model: fixed latency, results from the sample queue
    int cnt = 0;
    always @(negedge clk) begin
        conv_done <= 1'b0;
        if (conv_start) begin
            n_start <= n_start + 1;
            cnt <= LAT;
        end else if (cnt > 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) begin
                conv_done   <= 1'b1;
                conv_result <= (samp_q.size() > 0) ? samp_q.pop_front() : 16'h0055;
            end
        end
    end

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: queue a sample and its expected result, then start
    task automatic drive_conv(logic [15:0] v);
        samp_q.push_back(v);
        exp_q.push_back(v);
        wr(4'd1, 8'h01);
        idle(LAT + 6);
    endtask

    // monitor side: pop expected and compare against the read-back result
    task automatic mon_result(string tag);
        logic [7:0] lo, hi;
        logic [15:0] e;
        e = exp_q.pop_front();
        rd(4'd5, lo);
        rd(4'd6, hi);
        check(tag, {hi, lo}, e);
    endtask

    task automatic win_case(logic [2:0] m, logic [15:0] v, logic e, string tag);
        logic [7:0] f;
        wr(4'd4, {5'd0, m});
        drive_conv(v);
        rd(4'd3, f);
        check(tag, {15'd0, f[1]}, {15'd0, e});
        mon_result(tag);
    endtask

    initial begin
        logic [7:0] d;
        int s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        rd(4'd0, d); check("R1 ctrl reset", {8'd0, d}, 16'h00);
        rd(4'd1, d); check("R1 cmd reset",  {8'd0, d}, 16'h00);
        rd(4'd3, d); check("R1 flags reset", {8'd0, d}, 16'h00);
        rd(4'd2, d); check("R1 ien reset", {8'd0, d}, 16'h00);
        check("R1 irq reset", {15'd0, irq}, 16'd0);
        check("R1 start reset", {15'd0, conv_start}, 16'd0);

        // R2: start while disabled
        s0 = n_start;
        wr(4'd1, 8'h01);
        rd(4'd1, d); check("R2 cmd stays 0", {8'd0, d}, 16'h00);
        idle(LAT + 4);
        check("R2 no start", 16'(n_start - s0), 16'd0);

        // R13: control fields
        wr(4'd0, 8'hBC);
        rd(4'd0, d); check("R13 ctrl readback", {8'd0, d}, 16'hBC);
        wr(4'd0, 8'h01);

        // R3/R5: single conversion
        s0 = n_start;
        samp_q.push_back(16'h1234); exp_q.push_back(16'h1234);
        wr(4'd1, 8'h01);
        rd(4'd1, d); check("R3 busy readback", {8'd0, d}, 16'h01);
        idle(LAT + 6);
        check("R3 one start", 16'(n_start - s0), 16'd1);
        rd(4'd1, d); check("R3 busy clears", {8'd0, d}, 16'h00);
        rd(4'd3, d); check("R5 ready flag", {8'd0, d}, 16'h01);

        // R9: irq masking
        check("R9 irq masked", {15'd0, irq}, 16'd0);
        wr(4'd2, 8'h01);
        check("R9 irq enabled", {15'd0, irq}, 16'd1);
        wr(4'd2, 8'h02);
        check("R9 irq other bit", {15'd0, irq}, 16'd0);
        wr(4'd2, 8'h01);

        // R10/R7: snapshot and read clear
        rd(4'd5, d); check("R5 result low", {8'd0, d}, 16'h34);
        void'(exp_q.pop_front());
        rd(4'd3, d); check("R7 read clears", {8'd0, d}, 16'h00);
        check("R7 irq drops", {15'd0, irq}, 16'd0);
        drive_conv(16'hABCD);
        rd(4'd6, d); check("R10 snapshot held", {8'd0, d}, 16'h12);
        mon_result("R10 new result");

        // R8: write-1 clear, write-0 no effect
        drive_conv(16'h0777);
        void'(exp_q.pop_front());
        wr(4'd3, 8'h00);
        rd(4'd3, d); check("R8 write 0 keeps", {8'd0, d}, 16'h01);
        wr(4'd3, 8'h01);
        rd(4'd3, d); check("R8 write 1 clears", {8'd0, d}, 16'h00);

        // R4: write 0 no start, queued start
        s0 = n_start;
        wr(4'd1, 8'h00);
        idle(LAT + 4);
        check("R4 zero no start", 16'(n_start - s0), 16'd0);
        samp_q.push_back(16'h0111); samp_q.push_back(16'h0222);
        wr(4'd1, 8'h01);
        wr(4'd1, 8'h01);
        idle(3 * LAT + 10);
        check("R4 queued count", 16'(n_start - s0), 16'd2);
        exp_q.push_back(16'h0222);
        mon_result("R4 last result");

        // R6: window modes, low=0x0100 high=0x0200
        wr(4'd7, 8'h00); wr(4'd8, 8'h01);
        wr(4'd9, 8'h00); wr(4'd10, 8'h02);
        win_case(3'd1, 16'h0080, 1'b1, "R6 below hit");
        win_case(3'd2, 16'h0080, 1'b0, "R6 above miss");
        win_case(3'd2, 16'h0201, 1'b1, "R6 above hit");
        win_case(3'd3, 16'h0100, 1'b1, "R6 inside edge");
        win_case(3'd3, 16'h0201, 1'b0, "R6 inside miss");
        win_case(3'd4, 16'h0150, 1'b0, "R6 outside miss");
        win_case(3'd4, 16'h0300, 1'b1, "R6 outside hit");
        win_case(3'd0, 16'h0080, 1'b0, "R6 off");
        win_case(3'd6, 16'h0080, 1'b0, "R6 reserved");

        // R11: continuous chain, then R12 disable stops it
        s0 = n_start;
        wr(4'd0, 8'h03);
        wr(4'd1, 8'h01);
        idle(40);
        check("R11 chain runs", 16'(n_start - s0 >= 4), 16'd1);
        wr(4'd0, 8'h02);
        idle(LAT + 6);
        s0 = n_start;
        idle(20);
        check("R12 chain stops", 16'(n_start - s0), 16'd0);
        rd(4'd1, d); check("R12 cmd idle", {8'd0, d}, 16'h00);

        // R12: abort mid conversion
        samp_q.delete();
        wr(4'd3, 8'h03);
        wr(4'd0, 8'h01);
        wr(4'd1, 8'h01);
        wr(4'd0, 8'h00);
        rd(4'd1, d); check("R12 busy dropped", {8'd0, d}, 16'h00);
        idle(LAT + 8);
        rd(4'd3, d); check("R12 no flags", {8'd0, d}, 16'h00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule